// File: doc/BRIEF.md
# Watchdog and Reset Pulse Controller

This block is a synchronous supervisor core. It watches a watchdog service input and drives a system reset. It runs from one timing clock. The service input reaches it as two digital signals. The first is a level. The second is a flag that marks the input as floating at mid-supply, and while that flag is set the watchdog is off. Two more conditions come in already digitised: a low-line flag and a supply-below-battery flag. Either one holds reset active. Once both clear, reset stays active for a fixed number of clock cycles.

The service input passes through a two-stage synchroniser. After that, any change of its level or of its mid-level flag restarts the watchdog count. If no change arrives within the selected period, the fault output goes low and a reset pulse of the hold length is issued. The fault stays low until the next change of the service input. It is also forced inactive while the low-line flag is set. A select input picks the long or short period.

Top module: `wdt_supervisor`

## Requirements
- R1: With the period select at 1 the period P is LONG_CYC, and with it at 0 P is SHORT_CYC. When the service input is changed and then left alone, reset falls on the (P+3)-th rising clock edge after the change. Three of those edges come from the two synchroniser stages and edge detection. The internal count never exceeds LONG_CYC-1.
- R2: Each change of the service level, rising or falling, restarts the count. Changes spaced up to P cycles apart never cause a timeout.
- R3: A timeout drives wdo_no low on the same edge that reset falls. The reset pulse then lasts exactly HOLD_CYC clock edges.
- R4: After a timeout, wdo_no stays low through the reset pulse and after it. It returns high on the third rising edge after the next change of the service input.
- R5: While the mid-level flag is 1, no timeout occurs and level changes have no effect. Entering mid-level returns a low wdo_no to high on the third rising edge.
- R6: Reset (rst_no = 0) is asserted on the first rising edge after low_line_i or below_batt_i becomes 1. It stays asserted while either flag is 1.
- R7: Once both flags are 0, reset stays asserted for HOLD_CYC rising edges and is then released.
- R8: While low_line_i is 1, wdo_no is 1 with no clock delay. A pending fault is cleared by it.
- R9: rst_o is always the inverse of rst_no.
- R10: The watchdog count is held at zero while reset is asserted. If no service change arrives after a release, the next timeout comes P rising edges after the release.
- R11: While rst_ni is low, reset is asserted. After rst_ni rises, reset is released on the HOLD_CYC-th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous power-on clear, active low |
| wdi_lvl_i | input | 1 | Service input level |
| wdi_mid_i | input | 1 | Service input at mid-level (watchdog disabled) |
| low_line_i | input | 1 | Low-line condition, active high |
| below_batt_i | input | 1 | Supply below battery, active high |
| long_sel_i | input | 1 | 1 selects the long period, 0 the short one |
| rst_no | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |
| wdo_no | output | 1 | Watchdog fault, active low |

## Verification
The bench builds the block with LONG_CYC=40, SHORT_CYC=12 and HOLD_CYC=7, so every timeout and every hold is a few dozen cycles long. With periods this short, the bench can sweep every service spacing from 1 up to P in both period modes and show that none of them trips. It can then measure the first failing spacing exactly, along with the reset width and the re-trip interval after release. The same small hold makes it cheap to time the release after power-on, after low-line and after supply-below-battery.

// File: rtl/wdt_supervisor_pkg.sv
package wdt_supervisor_pkg;
  typedef struct packed {
    logic mid;
    logic lvl;
  } wdi_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i > 0) ? i-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_supervisor_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 1024,
  localparam int CW = $clog2(LONG_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wdi_t          wdi_i,
  input  logic          long_sel_i,
  input  logic          hold_i,
  input  logic          low_line_i,
  output logic          trip_o,
  output logic          fault_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LongLim  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] ShortLim = CW'(SHORT_CYC - 1);

  wdi_t          prev_q;
  logic          evt;
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_q;
  logic          fault_q;

  assign evt    = (wdi_i != prev_q);
  assign lim    = long_sel_i ? LongLim : ShortLim;
  // period switch mid-count: >= so a shorter limit still trips
  assign trip_o = !hold_i && !wdi_i.mid && !evt && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= wdi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (hold_i || wdi_i.mid || evt) cnt_q <= '0;
    else if (cnt_q < lim) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else if (low_line_i || evt) fault_q <= 1'b0;
    else if (trip_o) fault_q <= 1'b1;
  end

  assign fault_o = fault_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/wdt_hold.sv
module wdt_hold #(
  parameter int HOLD_CYC = 1000,
  localparam int HW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  output logic active_o
);
  localparam logic [HW-1:0] HoldLim = HW'(HOLD_CYC - 1);

  logic          act_q;
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (force_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == HoldLim) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_supervisor_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 1024,
  parameter int HOLD_CYC  = 1000,
  localparam int CW = $clog2(LONG_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_lvl_i,
  input  logic wdi_mid_i,
  input  logic low_line_i,
  input  logic below_batt_i,
  input  logic long_sel_i,
  output logic rst_no,
  output logic rst_o,
  output logic wdo_no
);
  wdi_t          wdi_raw;
  wdi_t          wdi_s;
  logic          trip;
  logic          fault;
  logic          rst_act;
  logic [CW-1:0] wd_cnt;

  assign wdi_raw = '{mid: wdi_mid_i, lvl: wdi_lvl_i};

  wdt_sync #(.WIDTH($bits(wdi_t)), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (wdi_raw),
    .q_o    (wdi_s)
  );

  wdt_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdi_i      (wdi_s),
    .long_sel_i (long_sel_i),
    .hold_i     (rst_act),
    .low_line_i (low_line_i),
    .trip_o     (trip),
    .fault_o    (fault),
    .cnt_o      (wd_cnt)
  );

  wdt_hold #(.HOLD_CYC(HOLD_CYC)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .force_i  (low_line_i | below_batt_i | trip),
    .active_o (rst_act)
  );

  assign rst_no = ~rst_act;
  assign rst_o  = rst_act;
  assign wdo_no = ~(fault & ~low_line_i);
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
  parameter int LONG_CYC = 4096,
  parameter int HOLD_CYC = 1000,
  parameter int CW       = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wdi_mid_i,
  input logic          low_line_i,
  input logic          below_batt_i,
  input logic          rst_no,
  input logic          wdo_no,
  input logic [CW-1:0] wd_cnt
);
  int lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_cnt <= 0;
    else if (low_line_i || below_batt_i || rst_no) lo_cnt <= 0;
    else if (lo_cnt <= HOLD_CYC) lo_cnt <= lo_cnt + 1;
  end

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_cnt <= CW'(LONG_CYC - 1));
  p_fault_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdo_no) |-> $fell(rst_no));
  p_mid_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdi_mid_i && $past(wdi_mid_i) && $past(wdi_mid_i, 2) && $past(wdi_mid_i, 3) |-> wdo_no);
  p_lowline_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_line_i |=> !rst_no);
  p_batt_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    below_batt_i |=> !rst_no);
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(!low_line_i && !below_batt_i));
  p_hold_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_cnt <= HOLD_CYC);
  p_lowline_wdo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_line_i |-> wdo_no);
  p_cnt_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |=> (wd_cnt == '0));
endmodule

bind wdt_supervisor wdt_supervisor_chk #(
  .LONG_CYC (LONG_CYC),
  .HOLD_CYC (HOLD_CYC),
  .CW       (CW)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wdi_mid_i    (wdi_mid_i),
  .low_line_i   (low_line_i),
  .below_batt_i (below_batt_i),
  .rst_no       (rst_no),
  .wdo_no       (wdo_no),
  .wd_cnt       (wd_cnt)
);

// File: tb/test_wdt_supervisor.sv
module test_wdt_supervisor;
  localparam int LP   = 40;
  localparam int SP   = 12;
  localparam int HOLD = 7;

  logic clk_i = 1'b0;
  logic rst_ni, lvl, mid, ll, bb, sel;
  logic rst_no, rst_o, wdo_no;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  wdt_supervisor #(.LONG_CYC(LP), .SHORT_CYC(SP), .HOLD_CYC(HOLD)) i_wdt_supervisor (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdi_lvl_i(lvl), .wdi_mid_i(mid),
    .low_line_i(ll), .below_batt_i(bb), .long_sel_i(sel),
    .rst_no(rst_no), .rst_o(rst_o), .wdo_no(wdo_no)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic until_rst(input logic v, output int n);
    n = 0;
    while (rst_no !== v && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic until_wdo(input logic v, output int n);
    n = 0;
    while (wdo_no !== v && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    int p;
    bit ok;
    rst_ni = 1'b0; lvl = 1'b0; mid = 1'b1; ll = 1'b0; bb = 1'b0; sel = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R11 rst_no in reset", rst_no, 0);
    chk("R9 rst_o in reset", rst_o, 1);
    chk("R5 wdo_no in reset", wdo_no, 1);
    rst_ni = 1'b1;
    until_rst(1'b1, n);
    chk("R11 power-on hold", n, HOLD);

    ok = 1'b1;
    repeat (3 * LP) begin
      @(negedge clk_i);
      if (!rst_no || !wdo_no) ok = 1'b0;
    end
    for (int i = 0; i < 20; i++) begin
      lvl = ~lvl;
      @(negedge clk_i);
      if (!rst_no || !wdo_no) ok = 1'b0;
    end
    chk("R5 mid-level disables", ok, 1);

    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      p = s ? LP : SP;
      for (int g = 1; g <= p; g++) begin
        ok = 1'b1;
        mid = 1'b0;
        for (int t = 0; t < 4; t++) begin
          repeat (g) begin
            @(negedge clk_i);
            if (!rst_no || !wdo_no) ok = 1'b0;
          end
          lvl = ~lvl;
        end
        mid = 1'b1;
        repeat (5) @(negedge clk_i);
        chk($sformatf("R2 spacing %0d sel %0d", g, s), ok, 1);
      end
      mid = 1'b0;
      until_rst(1'b0, n);
      chk($sformatf("R1 timeout sel %0d", s), n, p + 3);
      chk("R3 fault with timeout", wdo_no, 0);
      chk("R9 rst_o during pulse", rst_o, 1);
      until_rst(1'b1, n);
      chk("R3 pulse width", n, HOLD);
      chk("R4 fault held after pulse", wdo_no, 0);
      chk("R9 rst_o after pulse", rst_o, 0);
      until_rst(1'b0, n);
      chk($sformatf("R10 re-trip sel %0d", s), n, p);
      until_rst(1'b1, n);
      lvl = ~lvl;
      until_wdo(1'b1, n);
      chk("R4 fault cleared by edge", n, 3);
      mid = 1'b1;
      repeat (5) @(negedge clk_i);
    end

    sel = 1'b0;
    mid = 1'b0;
    until_rst(1'b0, n);
    until_rst(1'b1, n);
    chk("R4 fault before low-line", wdo_no, 0);
    mid = 1'b1;
    ll = 1'b1;
    #1;
    chk("R8 low-line forces wdo high", wdo_no, 1);
    @(negedge clk_i);
    chk("R6 low-line asserts reset", rst_no, 0);
    ok = 1'b1;
    repeat (30) begin
      @(negedge clk_i);
      if (rst_no || !wdo_no) ok = 1'b0;
    end
    chk("R6 reset held in low-line", ok, 1);
    ll = 1'b0;
    until_rst(1'b1, n);
    chk("R7 hold after low-line", n, HOLD);
    chk("R8 fault cleared by low-line", wdo_no, 1);

    bb = 1'b1;
    @(negedge clk_i);
    chk("R6 below-battery asserts reset", rst_no, 0);
    ok = 1'b1;
    repeat (30) begin
      @(negedge clk_i);
      if (rst_no) ok = 1'b0;
    end
    chk("R6 reset held below battery", ok, 1);
    bb = 1'b0;
    until_rst(1'b1, n);
    chk("R7 hold after below-battery", n, HOLD);

    mid = 1'b0;
    until_rst(1'b0, n);
    chk("R1 short timeout after idle", n, SP + 3);
    until_rst(1'b1, n);
    mid = 1'b1;
    until_wdo(1'b1, n);
    chk("R5 mid entry clears fault", n, 3);
    repeat (3 * LP) @(negedge clk_i);
    chk("R5 no trip under mid", rst_no, 1);
    finish_run();
  end
endmodule